// File: doc/BRIEF.md
# Mode-Dependent Effective Address Generator

This block forms an effective storage address by adding a base, an index and a displacement, then wrapping the sum to the addressing width currently in force. That width is chosen per operation from three choices: a low width (24 bits by default), a middle width (31 bits by default) and the full operand width (64 bits by default). Two addressing bits from the program status word, together with an architecture-mode bit, make the choice. Any of the three may change from one operation to the next.

The unit also rejects illegal combinations of these bits. A rejected operation still produces an output valid strobe one cycle later, with a specification-error flag set and the address forced to zero. The result is registered, so each accepted operation appears on the outputs exactly one clock after its input strobe. Operations can be issued back to back.

Top module: `eag_top`

## Requirements
- R1: With `amode` = 2'b00 (extended bit 0, basic bit 0), in either architecture mode, the address is the sum reduced modulo 2^LOW_W and no error is flagged.
- R2: With `amode` = 2'b01 (extended bit 0, basic bit 1), in either architecture mode, the address is the sum reduced modulo 2^MID_W and no error is flagged.
- R3: With `amode` = 2'b11 and `arch_wide` = 1, the address is the sum reduced modulo 2^OPW and no error is flagged.
- R4: With `amode` = 2'b10 (extended bit set, basic bit clear), a specification error is flagged in either architecture mode.
- R5: With `arch_wide` = 0, any operation whose extended bit (`amode[1]`) is 1 flags a specification error.
- R6: The three operands are added modulo 2^OPW. Every output bit at or above the active width is zero, so carries out of the active width are discarded.
- R7: `out_vld` is high in exactly the cycle after a cycle in which `in_vld` is high. Results come out in issue order, one per cycle.
- R8: When the error flag is set, `out_ea` is zero. `out_err` is never high unless `out_vld` is high.
- R9: In the cycle after `in_vld` is low, `out_vld` and `out_err` are low and `out_ea` keeps its previous value, whatever the other inputs carry.
- R10: `amode[1]` is the extended-addressing bit (status bit 31, counted from the MSB) and `amode[0]` is the basic-addressing bit (status bit 32).
- R11: The architecture and addressing bits are sampled with each operand set. A change between consecutive back-to-back operations takes effect on the very next result.
- R12: After reset, `out_vld`, `out_err` and `out_ea` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operand set valid |
| arch_wide | input | 1 | 1 = wide architecture mode, 0 = narrow |
| amode | input | 2 | Status-word addressing bits: [1] extended, [0] basic |
| base | input | OPW | Base operand |
| index | input | OPW | Index operand |
| disp | input | OPW | Displacement operand |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| out_ea | output | OPW | Wrapped effective address |
| out_err | output | 1 | Specification error for this result |

## Verification
The bench builds the block with OPW = 12, LOW_W = 4 and MID_W = 7. At these widths every base value can be swept under all eight combinations of the architecture and addressing bits, paired with generated index and displacement values. The narrow widths mean that wraps past each of the three boundaries occur on a large fraction of the operations instead of rarely, and the all-ones operand corners exercise every carry out of the active width. Idle cycles and a segment that changes the mode bits on every back-to-back operation cover output holding and per-operation mode sampling.

// File: rtl/eag_pkg.sv
package eag_pkg;
   typedef enum logic [1:0] {
      AW_LOW  = 2'd0,
      AW_MID  = 2'd1,
      AW_FULL = 2'd2
   } aw_sel_e;
endpackage

// File: rtl/eag_mode_dec.sv
module eag_mode_dec
   import eag_pkg::*;
(
   input  logic    arch_wide,
   input  logic    ext_bit,
   input  logic    bas_bit,
   output aw_sel_e sel,
   output logic    spec_err
);
   // extended without basic is illegal; extended is illegal in narrow mode
   always_comb begin
      spec_err = ext_bit & (~bas_bit | ~arch_wide);
      if (ext_bit & bas_bit)
         sel = AW_FULL;
      else if (bas_bit)
         sel = AW_MID;
      else
         sel = AW_LOW;
   end
endmodule

// File: rtl/eag_adder.sv
module eag_adder #(
   parameter int W = 64
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   output logic [W-1:0] sum
);
   // modulo 2^W three-operand sum; carries past W are dropped
   always_comb sum = a + b + c;
endmodule

// File: rtl/eag_wrap.sv
module eag_wrap
   import eag_pkg::*;
#(
   parameter int W     = 64,
   parameter int LOW_W = 24,
   parameter int MID_W = 31
) (
   input  aw_sel_e      sel,
   input  logic [W-1:0] raw,
   output logic [W-1:0] wrapped
);
   logic [W-1:0] keep;

   // per-bit keep enable: the region a bit lies in fixes which widths retain it
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i < LOW_W) begin : g_low
         assign keep[i] = 1'b1;
      end else if (i < MID_W) begin : g_mid
         assign keep[i] = (sel == AW_MID) || (sel == AW_FULL);
      end else begin : g_top
         assign keep[i] = (sel == AW_FULL);
      end
   end

   assign wrapped = raw & keep;
endmodule

// File: rtl/eag_top.sv
module eag_top
   import eag_pkg::*;
#(
   parameter int OPW   = 64,
   parameter int LOW_W = 24,
   parameter int MID_W = 31
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_vld,
   input  logic           arch_wide,
   input  logic [1:0]     amode,
   input  logic [OPW-1:0] base,
   input  logic [OPW-1:0] index,
   input  logic [OPW-1:0] disp,
   output logic           out_vld,
   output logic [OPW-1:0] out_ea,
   output logic           out_err
);
   localparam int EXT_IDX = 1;
   localparam int BAS_IDX = 0;

   if (!(LOW_W > 0 && LOW_W < MID_W && MID_W < OPW)) begin : g_bad_widths
      $error("eag_top: widths must satisfy 0 < LOW_W < MID_W < OPW");
   end

   aw_sel_e        sel;
   logic           spec_err;
   logic [OPW-1:0] raw_sum;
   logic [OPW-1:0] wrapped;

   eag_mode_dec u_dec (
      .arch_wide (arch_wide),
      .ext_bit   (amode[EXT_IDX]),
      .bas_bit   (amode[BAS_IDX]),
      .sel       (sel),
      .spec_err  (spec_err)
   );

   eag_adder #(.W(OPW)) u_add (
      .a   (base),
      .b   (index),
      .c   (disp),
      .sum (raw_sum)
   );

   eag_wrap #(.W(OPW), .LOW_W(LOW_W), .MID_W(MID_W)) u_wrap (
      .sel     (sel),
      .raw     (raw_sum),
      .wrapped (wrapped)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_err <= 1'b0;
         out_ea  <= '0;
      end else begin
         out_vld <= in_vld;
         out_err <= in_vld & spec_err;
         if (in_vld)
            out_ea <= spec_err ? '0 : wrapped;
      end
   end
endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
   parameter int OPW   = 64,
   parameter int LOW_W = 24,
   parameter int MID_W = 31
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_vld,
   input logic           arch_wide,
   input logic [1:0]     amode,
   input logic [OPW-1:0] out_ea,
   input logic           out_vld,
   input logic           out_err
);
   a_r7_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);
   a_r9_idle_no_vld: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> (!out_vld && !out_err));
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(out_ea));
   a_r8_err_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> out_vld);
   a_r8_err_zero_ea: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> (out_ea == '0));
   a_r5_narrow_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !arch_wide && amode[1]) |=> out_err);
   a_r4_ext_no_bas: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && amode == 2'b10) |=> out_err);
   a_r1_low_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && amode == 2'b00) |=> (!out_err && (out_ea >> LOW_W) == '0));
   a_r2_mid_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && amode == 2'b01) |=> (!out_err && (out_ea >> MID_W) == '0));
   a_r3_full_no_err: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && arch_wide && amode == 2'b11) |=> !out_err);
endmodule

bind eag_top eag_chk #(.OPW(OPW), .LOW_W(LOW_W), .MID_W(MID_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_vld    (in_vld),
   .arch_wide (arch_wide),
   .amode     (amode),
   .out_ea    (out_ea),
   .out_vld   (out_vld),
   .out_err   (out_err)
);

// File: tb/eag_top_tb_top.sv
module eag_top_tb_top;
   localparam int OPW   = 12;
   localparam int LOW_W = 4;
   localparam int MID_W = 7;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_vld = 1'b0;
   logic           arch_wide = 1'b0;
   logic [1:0]     amode = 2'b00;
   logic [OPW-1:0] base = '0, index = '0, disp = '0;
   logic           out_vld, out_err;
   logic [OPW-1:0] out_ea;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [31:0] lcg = 32'h1234_5677;
   logic [OPW-1:0] last_ea = '0;

   always #2 clk = ~clk;

   eag_top #(.OPW(OPW), .LOW_W(LOW_W), .MID_W(MID_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .arch_wide(arch_wide),
      .amode(amode), .base(base), .index(index), .disp(disp),
      .out_vld(out_vld), .out_ea(out_ea), .out_err(out_err)
   );

   task automatic check(input string tag, input logic [OPW-1:0] act,
                        input logic [OPW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [OPW-1:0] next_rand();
      lcg = lcg * 32'd1103515245 + 32'd12345;
      return lcg[27:16];
   endfunction

   // drive one operation just after a falling edge, check it at the next one
   task automatic issue(input logic aw, input logic [1:0] am,
                        input logic [OPW-1:0] b, input logic [OPW-1:0] x,
                        input logic [OPW-1:0] d, input string grp);
      logic [OPW-1:0] sum;
      logic [OPW-1:0] exp;
      logic           err;
      string          tag;
      arch_wide = aw; amode = am; base = b; index = x; disp = d; in_vld = 1'b1;
      sum = b + x + d;
      err = am[1] && (!am[0] || !aw);
      if (err) begin
         exp = '0;
         tag = aw ? "R4 R8" : "R5 R8";
      end else if (am == 2'b11) begin
         exp = sum;
         tag = "R3 R6";
      end else if (am == 2'b01) begin
         exp = sum % (1 << MID_W);
         tag = "R2 R6";
      end else begin
         exp = sum % (1 << LOW_W);
         tag = "R1 R6";
      end
      @(negedge clk);
      check({grp, " R7 vld"}, OPW'(out_vld), OPW'(1));
      check({grp, " ", tag, " R10 err"}, OPW'(out_err), OPW'(err));
      check({grp, " ", tag, " ea"}, out_ea, exp);
      last_ea = exp;
   endtask

   task automatic idle_check();
      in_vld = 1'b0;
      arch_wide = ~arch_wide; amode = 2'b10;
      base = next_rand(); index = next_rand(); disp = next_rand();
      @(negedge clk);
      check("R9 idle vld", OPW'(out_vld), OPW'(0));
      check("R9 idle err", OPW'(out_err), OPW'(0));
      check("R9 idle hold ea", out_ea, last_ea);
   endtask

   initial begin
      #(4 * 190000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R12 reset vld", OPW'(out_vld), OPW'(0));
      check("R12 reset err", OPW'(out_err), OPW'(0));
      check("R12 reset ea", out_ea, '0);
      rst_n = 1'b1;
      @(negedge clk);
      // full base sweep under every mode combination
      for (int c = 0; c < 8; c++) begin
         for (int b = 0; b < (1 << OPW); b++) begin
            issue(c[2], c[1:0], OPW'(b), next_rand(), next_rand(), "sweep");
         end
         issue(c[2], c[1:0], '1, '1, '1, "allones");
         issue(c[2], c[1:0], '1, OPW'(1), '0, "carry");
         idle_check();
      end
      // R11: mode bits change on every back-to-back operation
      for (int i = 0; i < 64; i++) begin
         issue(i[0], {i[2], i[1]}, next_rand(), next_rand(), next_rand(), "R11 switch");
      end
      idle_check();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule